// File: doc/BRIEF.md
# Redundant Strong-Bit Majority Key Encoder

This block turns a serial stream of physically derived bits into key bits. Every input beat carries one candidate bit and a flag that marks it as strong or weak. Weak beats are taken from the stream and dropped. Strong beats are dealt out in strict rotation over an odd number N of redundant copies, so that one key position is filled once per group of N strong bits. The block can run in one of two modes. In enrollment mode the key bit is the value held by the first copy of each group. In regeneration mode the key bit is the majority vote of the N copies, so up to (N-1)/2 disagreeing copies have no effect on the result.

A run begins with a one-cycle `start` pulse. The pulse latches the mode, the redundancy code and the requested key length. Input beats come in over a valid/ready handshake. A beat transfers on a rising edge where `in_valid` and `in_ready` are both high. Key bits leave over a second valid/ready handshake. A key bit that is offered stays stable until the consumer takes it. While that bit waits, `in_ready` is held low, so back-pressure from the output reaches the input with no internal buffering. The run stops when the requested number of key bits has been produced. It also stops, with an error flag, when a beat marked last arrives before that point.

Top module: `mke_key_encoder`

## Requirements
- R1: After reset the block is idle. `in_ready`, `key_valid`, `done` and `err` are 0 and `key_count` is 0.
- R2: A transferred beat with `in_strong`=0 changes no copy, no key bit and no count. It is still accepted.
- R3: Strong bit number s of a run (counting from 0) feeds key bit s/N as copy s mod N. The key bit is offered on `key_valid` in the cycle after its N-th copy transfers.
- R4: `red_code` is sampled at `start` and selects N: 0 gives 3, 1 gives 5, 2 gives 7, 3 gives 9.
- R5: With `mode_regen`=1, a key bit is 1 exactly when at least (N+1)/2 of its N copies are 1.
- R6: With `mode_regen`=0, a key bit equals its copy 0, which is the first strong bit of its group.
- R7: While `key_valid`=1 and `key_ready`=0, `key_bit` holds and `key_valid` stays high. `in_ready` is 0 whenever a key bit is pending.
- R8: `key_count` gives the number of key bits produced in the run. When it reaches the length sampled at `start`, `done` goes to 1, `err` stays 0 and no further beat is accepted.
- R9: A beat with `in_last`=1 that leaves `key_count` below the requested length ends the run with `done`=1 and `err`=1. A partly filled group is dropped.
- R10: A `start` with a requested length of 0 gives `done`=1 and `err`=0 in the next cycle, with no beat accepted.
- R11: `start` restarts the block in any state. It clears `key_count`, `err`, `done` and any partly filled group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins a run and latches the settings |
| mode_regen | input | 1 | 1 = majority vote (regeneration), 0 = first copy (enrollment) |
| red_code | input | 2 | Redundancy select: N = 3, 5, 7, 9 |
| key_len | input | CW | Requested number of key bits (CW = clog2(MAX_KEY+1)) |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts a beat this cycle |
| in_bit | input | 1 | Candidate bit |
| in_strong | input | 1 | Helper flag: 1 = strong, use the bit; 0 = weak, skip it |
| in_last | input | 1 | Final beat of the stream |
| key_valid | output | 1 | Key bit offered |
| key_ready | input | 1 | Consumer takes the key bit |
| key_bit | output | 1 | Key bit value |
| key_count | output | CW | Key bits produced in this run |
| done | output | 1 | Run finished |
| err | output | 1 | Stream ended before the requested length was reached |

## Verification
The bench uses the default parameters. With the default count width, a single run can ask for 512 key bits. Because of that, regeneration mode is swept over every one of the 2^N copy patterns for each of the four redundancy settings, and enrollment mode is swept in the same way for N = 3 and 5. These sweeps have weak beats mixed in and the output consumer stalls on a fixed pattern. Pseudo-random streams are run in both modes and at every N, with key lengths chosen so that some runs finish on time and some end short. Directed runs cover a stalled output, a zero-length request and a restart in the middle of a run.

// File: rtl/mke_pkg.sv
`timescale 1ns/1ps
package mke_pkg;

  localparam int RED_MAX = 9;
  localparam int OW      = $clog2(RED_MAX + 1);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } mke_state_e;

  function automatic logic [OW-1:0] red_to_n(input logic [1:0] code);
    logic [OW-1:0] n;
    case (code)
      2'd0:    n = OW'(3);
      2'd1:    n = OW'(5);
      2'd2:    n = OW'(7);
      default: n = OW'(9);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/mke_copy_sel.sv
`timescale 1ns/1ps
module mke_copy_sel
  import mke_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [OW-1:0] n,
  output logic [OW-1:0] copy_idx,
  output logic          grp_end
);

  // step is one strong beat; the group closes on copy N-1
  assign grp_end = step && (copy_idx == n - OW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      copy_idx <= '0;
    end else if (clr) begin
      copy_idx <= '0;
    end else if (step) begin
      copy_idx <= grp_end ? '0 : copy_idx + OW'(1);
    end
  end

  AST_COPY_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    copy_idx < n) else $error("copy index out of range"); // R3

  AST_WRAP_AFTER_GROUP: assert property (@(posedge clk) disable iff (!rst_n || clr)
    grp_end |=> copy_idx == '0) else $error("copy index did not wrap"); // R3

endmodule

// File: rtl/mke_vote.sv
`timescale 1ns/1ps
module mke_vote
  import mke_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic          bit_in,
  input  logic          first,
  input  logic          grp_end,
  input  logic [OW-1:0] n,
  input  logic          regen,
  output logic          dec
);

  logic [OW-1:0] ones_q;
  logic          first_q;
  logic [OW:0]   ones_tot;
  logic [OW:0]   thresh;

  assign ones_tot = {1'b0, ones_q} + {{OW{1'b0}}, bit_in};
  assign thresh   = ({1'b0, n} + (OW+1)'(1)) >> 1;
  // N is at least 3, so the closing beat is never copy 0
  assign dec      = regen ? (ones_tot >= thresh) : first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q  <= '0;
      first_q <= 1'b0;
    end else if (clr) begin
      ones_q  <= '0;
      first_q <= 1'b0;
    end else if (step) begin
      ones_q <= grp_end ? '0 : ones_tot[OW-1:0];
      if (first) first_q <= bit_in;
    end
  end

  AST_ONES_BELOW_N: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q < n) else $error("ones tally reached N"); // R5

  AST_TALLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n || clr)
    grp_end |=> ones_q == '0) else $error("tally kept after group"); // R5

endmodule

// File: rtl/mke_key_encoder.sv
`timescale 1ns/1ps
module mke_key_encoder
  import mke_pkg::*;
#(
  parameter int MAX_KEY = 4096,
  localparam int CW     = $clog2(MAX_KEY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode_regen,
  input  logic [1:0]    red_code,
  input  logic [CW-1:0] key_len,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_bit,
  input  logic          in_strong,
  input  logic          in_last,
  output logic          key_valid,
  input  logic          key_ready,
  output logic          key_bit,
  output logic [CW-1:0] key_count,
  output logic          done,
  output logic          err
);

  mke_state_e    state;
  logic          regen_q;
  logic [OW-1:0] n_q;
  logic [CW-1:0] len_q;

  logic          acc;
  logic          step;
  logic          grp_end;
  logic          dec;
  logic [OW-1:0] copy_idx;
  logic [CW-1:0] cnt_nx;
  logic          emit;

  assign in_ready = (state == ST_RUN) && !key_valid;
  assign acc      = in_valid && in_ready && !start;
  assign step     = acc && in_strong;
  assign emit     = grp_end;
  assign cnt_nx   = key_count + CW'(1);
  assign done     = (state == ST_DONE);

  mke_copy_sel u_copy_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start),
    .step     (step),
    .n        (n_q),
    .copy_idx (copy_idx),
    .grp_end  (grp_end)
  );

  mke_vote u_vote (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (start),
    .step    (step),
    .bit_in  (in_bit),
    .first   (copy_idx == '0),
    .grp_end (grp_end),
    .n       (n_q),
    .regen   (regen_q),
    .dec     (dec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      regen_q   <= 1'b0;
      n_q       <= OW'(3);
      len_q     <= '0;
      key_valid <= 1'b0;
      key_bit   <= 1'b0;
      key_count <= '0;
      err       <= 1'b0;
    end else if (start) begin
      state     <= (key_len == '0) ? ST_DONE : ST_RUN;
      regen_q   <= mode_regen;
      n_q       <= red_to_n(red_code);
      len_q     <= key_len;
      key_valid <= 1'b0;
      key_count <= '0;
      err       <= 1'b0;
    end else begin
      if (key_valid && key_ready) key_valid <= 1'b0;
      if (acc) begin
        if (emit) begin
          key_valid <= 1'b1;
          key_bit   <= dec;
          key_count <= cnt_nx;
        end
        if (emit && cnt_nx == len_q) begin
          state <= ST_DONE;
        end else if (in_last) begin
          state <= ST_DONE;
          err   <= 1'b1;
        end
      end
    end
  end

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n || start)
    key_valid && !key_ready |=> key_valid && $stable(key_bit))
    else $error("key bit dropped under back-pressure"); // R7

  AST_NO_TAKE_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready) else $error("beat accepted after done"); // R8

  AST_COUNT_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    key_count <= len_q) else $error("key count past request"); // R8

  AST_ERR_IMPLIES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done) else $error("error without done"); // R9

  AST_WEAK_INERT: assert property (@(posedge clk) disable iff (!rst_n || start)
    acc && !in_strong |=> $stable(key_count) && $stable(copy_idx))
    else $error("weak beat changed state"); // R2

endmodule

// File: tb/mke_key_encoder_tb_top.sv
`timescale 1ns/1ps
module mke_key_encoder_tb_top;

  localparam int MAX_KEY = 4096;
  localparam int CW      = $clog2(MAX_KEY + 1);
  localparam int SMAX    = 8192;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          mode_regen = 1'b0;
  logic [1:0]    red_code = 2'd0;
  logic [CW-1:0] key_len = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic          in_bit = 1'b0;
  logic          in_strong = 1'b0;
  logic          in_last = 1'b0;
  logic          key_valid;
  logic          key_ready = 1'b1;
  logic          key_bit;
  logic [CW-1:0] key_count;
  logic          done;
  logic          err;

  int n_chk = 0;
  int n_fail = 0;
  int gn = 0;
  int cyc = 0;
  bit bp_en = 0;
  bit bp_hold = 0;
  bit got [0:1023];
  bit expk [0:1023];
  bit sb [0:SMAX-1];
  bit ss [0:SMAX-1];

  always #10 clk = ~clk;

  mke_key_encoder #(.MAX_KEY(MAX_KEY)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_regen(mode_regen),
    .red_code(red_code), .key_len(key_len), .in_valid(in_valid),
    .in_ready(in_ready), .in_bit(in_bit), .in_strong(in_strong),
    .in_last(in_last), .key_valid(key_valid), .key_ready(key_ready),
    .key_bit(key_bit), .key_count(key_count), .done(done), .err(err)
  );

  always @(negedge clk) begin
    cyc = cyc + 1;
    key_ready = bp_hold ? 1'b0 : (bp_en ? (cyc % 3 != 0) : 1'b1);
  end

  always @(posedge clk) begin
    if (rst_n && key_valid && key_ready && gn < 1024) begin
      got[gn] = key_bit;
      gn = gn + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_start(input bit m, input int code, input int klen);
    @(negedge clk);
    start = 1'b1; mode_regen = m; red_code = code[1:0]; key_len = CW'(klen);
    gn = 0;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send_beat(input bit b, input bit s, input bit l, output bit ab);
    @(negedge clk);
    ab = 0;
    in_bit = b; in_strong = s; in_last = l; in_valid = 1'b1;
    while (!in_ready && !done) @(negedge clk);
    if (!in_ready) begin
      ab = 1;
      in_valid = 1'b0;
    end else begin
      @(posedge clk);
      #1 in_valid = 1'b0;
    end
  endtask

  task automatic drain();
    for (int w = 0; w < 60; w++) begin
      @(negedge clk);
      if (done && !key_valid) break;
    end
  endtask

  task automatic run(input int len, input int klen, input int code, input bit m);
    int nn, s, ones, kn;
    bit first, ab, exp_err;
    string rq;
    nn = 3 + 2 * code;
    s = 0; ones = 0; kn = 0; first = 0;
    for (int i = 0; i < len; i++) begin
      if (kn == klen) break;
      if (ss[i]) begin
        if (s == 0) first = sb[i];
        ones += int'(sb[i]);
        s++;
        if (s == nn) begin
          expk[kn] = m ? (ones >= (nn + 1) / 2) : first;
          kn++; s = 0; ones = 0;
        end
      end
    end
    exp_err = (kn < klen);
    rq = m ? "R5" : "R6";
    do_start(m, code, klen);
    for (int i = 0; i < len; i++) begin
      send_beat(sb[i], ss[i], i == len - 1, ab);
      if (ab) break;
    end
    drain();
    chk(gn == kn, "R3", "key bits delivered", gn, kn);
    for (int k = 0; k < kn && k < gn; k++)
      chk(got[k] == expk[k], rq, $sformatf("N=%0d key bit %0d", nn, k),
          int'(got[k]), int'(expk[k]));
    chk(int'(key_count) == kn, "R8", "key_count", int'(key_count), kn);
    chk(done == 1'b1, "R8", "done", int'(done), 1);
    chk(err == exp_err, "R9", "err", int'(err), int'(exp_err));
    chk(in_ready == 1'b0, "R8", "in_ready after end", int'(in_ready), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int L;
    bit ab;
    int unsigned x;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(in_ready == 0 && key_valid == 0 && done == 0 && err == 0,
        "R1", "idle flags", int'({in_ready, key_valid, done, err}), 0);
    chk(key_count == 0, "R1", "key_count", int'(key_count), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 zero-length request
    do_start(1'b1, 0, 0);
    chk(done == 1 && err == 0, "R10", "done/err", int'({done, err}), 2);
    chk(in_ready == 0, "R10", "in_ready", int'(in_ready), 0);

    // R2 weak beats accepted, no effect
    do_start(1'b1, 0, 1);
    for (int i = 0; i < 4; i++) begin
      send_beat(1'b1, 1'b0, 1'b0, ab);
      chk(ab == 0, "R2", "weak beat accepted", int'(ab), 0);
    end
    @(negedge clk);
    chk(key_count == 0 && key_valid == 0, "R2", "state after weak beats",
        int'(key_count), 0);
    send_beat(1'b0, 1'b1, 1'b0, ab);
    send_beat(1'b0, 1'b1, 1'b0, ab);
    send_beat(1'b1, 1'b1, 1'b0, ab);
    drain();
    chk(gn == 1 && got[0] == 0, "R2", "key bit ignoring weak ones",
        int'(got[0]), 0);

    // R7 back-pressure hold
    bp_hold = 1;
    do_start(1'b1, 0, 2);
    send_beat(1'b1, 1'b1, 1'b0, ab);
    send_beat(1'b0, 1'b1, 1'b0, ab);
    send_beat(1'b1, 1'b1, 1'b0, ab);
    repeat (4) @(negedge clk);
    chk(key_valid == 1 && key_bit == 1, "R7", "held key bit",
        int'({key_valid, key_bit}), 3);
    chk(in_ready == 0, "R7", "in_ready while pending", int'(in_ready), 0);
    bp_hold = 0;
    repeat (2) @(negedge clk);
    chk(gn == 1 && got[0] == 1, "R7", "bit after release", gn, 1);
    chk(in_ready == 1, "R7", "in_ready after release", int'(in_ready), 1);

    // R11 restart mid-run, after a partial group
    send_beat(1'b1, 1'b1, 1'b0, ab);
    do_start(1'b0, 1, 1);
    chk(key_count == 0 && err == 0 && done == 0, "R11", "cleared by start",
        int'(key_count), 0);
    for (int i = 0; i < 5; i++) send_beat(i == 0, 1'b1, 1'b0, ab);
    drain();
    chk(gn == 1 && got[0] == 1, "R11", "fresh group after restart",
        int'(got[0]), 1);

    // R4/R5 exhaustive vote patterns per N, with weak beats and stalls
    bp_en = 1;
    for (int code = 0; code < 4; code++) begin
      int nn;
      nn = 3 + 2 * code;
      L = 0;
      for (int p = 0; p < (1 << nn); p++)
        for (int c = 0; c < nn; c++) begin
          if ((p + c) % 3 == 0) begin sb[L] = ~p[c]; ss[L] = 0; L++; end
          sb[L] = p[c]; ss[L] = 1; L++;
        end
      run(L, 1 << nn, code, 1'b1);
      if (code < 2) run(L, 1 << nn, code, 1'b0); // R6
    end

    // R4/R8/R9 pseudo-random streams, both modes, all N
    x = 32'h1234_5678;
    for (int code = 0; code < 4; code++)
      for (int m = 0; m < 2; m++)
        for (int sd = 0; sd < 3; sd++) begin
          for (int i = 0; i < 120; i++) begin
            x ^= x << 13; x ^= x >> 17; x ^= x << 5;
            sb[i] = x[3]; ss[i] = x[9] | x[11];
          end
          run(120, (sd == 0) ? 2 : (sd == 1) ? 6 : 30, code, m[0]);
        end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule